// File: doc/BRIEF.md
# Shared Transmit Timestamp Queue

This block gathers transmit timestamps reported by several port interfaces and queues them in a single shared FIFO. A 32-bit register bus drains the FIFO. Each queued entry carries five fields:

- a 28-bit timestamp taken on the rising clock edge;
- a 4-bit low-order sample taken on the falling edge, which is stored but not interpreted;
- the number of the port that reported it;
- a 16-bit frame tag;
- a flag marking the timestamp as suspect because the timebase was being adjusted when it was captured.

One transmitted frame can produce entries from several ports that share the same frame tag but carry different port numbers. This is how broadcast and multicast frames appear.

Ports offer entries with a valid/ready pair. A round-robin arbiter accepts one entry per cycle. Software reads three readout words per entry. A level interrupt, gated by a mask, stays high while anything is queued.

A small two-state machine tracks the entry held for readout. Its states and transitions are:

- **HOLD_NONE**: no entry is held.
- **HOLD_VALID**: an entry has been popped and is held.
- **NONE→VALID**: a read of word 0 while the FIFO is not empty.
- **VALID→VALID**: the same event from HOLD_VALID; it replaces the held entry.
- **VALID→NONE**: a read of word 0 while the FIFO is empty.
- All other events keep the current state.

Top module: `txts_collector`

## Requirements
- R1: After reset the FIFO is empty, the mask is 0, `irq` is low, no `port_ready` bit is set, and the control/status word (0x1C) reads 0x0002_0000.
- R2: Writing 1 in bit 0 at 0x04 sets the interrupt mask, and writing 1 in bit 0 at 0x00 clears it. Writing 0 to either address has no effect. The mask reads back in bit 0 at 0x08, and writes to 0x08 are ignored.
- R3: `irq` and bit 0 at 0x0C both equal mask AND (FIFO not empty).
- R4: At most one `port_ready` bit is set per cycle, and only for a port whose `port_valid` is high. The search starts at the port after the last one granted and wraps, so simultaneous requests are served in rotating order, one entry per cycle.
- R5: The control/status word at 0x1C holds the fill count in bits [7:0], full in bit 16, empty in bit 17 and the overflow flag in bit 18.
- R6: Reading word 0 (0x10) pops the oldest entry and returns the rising-edge timestamp in [27:0] and the falling-edge sample in [31:28]. Read data appears on `bus_rdata` one cycle after the request.
- R7: Word 1 (0x14) returns the port number (the index of the granting `port_valid` bit) in [4:0] and the frame tag in [31:16] for the entry popped by the last word-0 read. Reading it does not pop.
- R8: Bit 0 of word 2 (0x18) is the value of `adj_busy` in the cycle the entry was accepted.
- R9: An entry accepted while the FIFO is full is discarded and sets the overflow flag. The flag stays set until bit 18 is written as 1 at 0x1C.
- R10: A word-0 read with an empty FIFO returns 0 and moves to HOLD_NONE. In HOLD_NONE, words 1 and 2 read 0.
- R11: Entries leave in acceptance order, and entries with equal frame tags from different ports are kept as separate entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_valid | input | N_PORTS | Per-port entry offer |
| port_ready | output | N_PORTS | Per-port accept (grant) |
| port_ts_rise | input | N_PORTS*28 | Rising-edge timestamps, port p at [p*28 +: 28] |
| port_ts_fall | input | N_PORTS*4 | Falling-edge samples, port p at [p*4 +: 4] |
| port_frame_id | input | N_PORTS*16 | Frame tags, port p at [p*16 +: 16] |
| adj_busy | input | 1 | Timebase adjustment in progress |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:

- the arbiter's grant is one-hot, lies inside the request set, and is never withheld while a request is present;
- the fill count stays within the FIFO depth and moves by at most one per cycle;
- the interrupt stays low whenever the FIFO is empty;
- the mask changes only on a write to the enable or disable address;
- the overflow flag sets on a dropped entry and stays set until it is cleared.

Only the bench scenarios can show the following:

- the rotating service order across every request subset;
- the field packing of the three readout words and the acceptance order of entries;
- that the suspect flag follows `adj_busy`;
- the drop at full, and the read-as-zero behaviour after an empty pop.

// File: rtl/txts_pkg.sv
package txts_pkg;
    localparam int TS_W  = 28;
    localparam int FS_W  = 4;
    localparam int PID_W = 5;
    localparam int FID_W = 16;

    typedef struct packed {
        logic             bad;
        logic [FID_W-1:0] fid;
        logic [PID_W-1:0] pid;
        logic [FS_W-1:0]  ts_f;
        logic [TS_W-1:0]  ts_r;
    } ts_entry_t;

    localparam int ENTRY_W = $bits(ts_entry_t);

    localparam logic [4:0] A_IDIS  = 5'h00;
    localparam logic [4:0] A_IEN   = 5'h04;
    localparam logic [4:0] A_IMASK = 5'h08;
    localparam logic [4:0] A_ISTAT = 5'h0C;
    localparam logic [4:0] A_W0    = 5'h10;
    localparam logic [4:0] A_W1    = 5'h14;
    localparam logic [4:0] A_W2    = 5'h18;
    localparam logic [4:0] A_CSR   = 5'h1C;

    localparam int CSR_FULL_BIT  = 16;
    localparam int CSR_EMPTY_BIT = 17;
    localparam int CSR_OVF_BIT   = 18;

    typedef enum logic {
        HOLD_NONE,
        HOLD_VALID
    } hold_state_t;
endpackage

// File: rtl/txts_rr_arbiter.sv
module txts_rr_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gidx
);
    logic [IW-1:0] ptr;
    logic          found;

    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (|req)
            ptr <= (gidx == IW'(N-1)) ? '0 : gidx + 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4
    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R4
    AST_GRANT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant)); // R4
endmodule

// File: rtl/txts_fifo.sv
module txts_fifo #(
    parameter int AW    = 8,
    parameter int WIDTH = 54,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH)); // R9
    AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count + 1'b1 == $past(count))); // R5
endmodule

// File: rtl/txts_collector.sv
module txts_collector
    import txts_pkg::*;
#(
    parameter int N_PORTS    = 4,
    parameter int DEPTH_LOG2 = 8,
    localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        port_valid,
    output logic [N_PORTS-1:0]        port_ready,
    input  logic [N_PORTS*TS_W-1:0]   port_ts_rise,
    input  logic [N_PORTS*FS_W-1:0]   port_ts_fall,
    input  logic [N_PORTS*FID_W-1:0]  port_frame_id,
    input  logic                      adj_busy,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [4:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq
);
    logic [N_PORTS-1:0]  grant;
    logic [IW-1:0]       gidx;
    ts_entry_t           new_entry, head, hold;
    logic [DEPTH_LOG2:0] count;
    logic                full, empty, push;
    logic                mask, ovf;
    logic                rd_w0, wr_en, wr_dis, wr_ovf_clr;
    hold_state_t         state, next_state;

    txts_rr_arbiter #(.N(N_PORTS)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (port_valid),
        .grant (grant),
        .gidx  (gidx)
    );

    assign port_ready = grant;
    assign push       = |grant;

    always_comb begin
        new_entry.ts_r = port_ts_rise[int'(gidx)*TS_W +: TS_W];
        new_entry.ts_f = port_ts_fall[int'(gidx)*FS_W +: FS_W];
        new_entry.fid  = port_frame_id[int'(gidx)*FID_W +: FID_W];
        new_entry.pid  = PID_W'(gidx);
        new_entry.bad  = adj_busy;
    end

    txts_fifo #(.AW(DEPTH_LOG2), .WIDTH(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (new_entry),
        .pop   (rd_w0),
        .dout  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    assign rd_w0      = bus_req && !bus_we && (bus_addr == A_W0);
    assign wr_en      = bus_req && bus_we && (bus_addr == A_IEN) && bus_wdata[0];
    assign wr_dis     = bus_req && bus_we && (bus_addr == A_IDIS) && bus_wdata[0];
    assign wr_ovf_clr = bus_req && bus_we && (bus_addr == A_CSR) && bus_wdata[CSR_OVF_BIT];
    assign irq        = mask && !empty;

    // hold state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HOLD_NONE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            HOLD_NONE:  if (rd_w0 && !empty) next_state = HOLD_VALID;
            HOLD_VALID: if (rd_w0 && empty)  next_state = HOLD_NONE;
        endcase
    end

    // outputs and registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            mask      <= 1'b0;
            ovf       <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_en)       mask <= 1'b1;
            else if (wr_dis) mask <= 1'b0;
            if (push && full)    ovf <= 1'b1;
            else if (wr_ovf_clr) ovf <= 1'b0;
            if (rd_w0)
                hold <= empty ? '0 : head;
            if (bus_req && !bus_we) begin
                case (bus_addr)
                    A_IMASK: bus_rdata <= {31'b0, mask};
                    A_ISTAT: bus_rdata <= {31'b0, irq};
                    A_W0:    bus_rdata <= empty ? '0 : {head.ts_f, head.ts_r};
                    A_W1:    bus_rdata <= (state == HOLD_NONE) ? '0
                                          : {hold.fid, 11'b0, hold.pid};
                    A_W2:    bus_rdata <= (state == HOLD_NONE) ? '0
                                          : {31'b0, hold.bad};
                    A_CSR:   bus_rdata <= {13'b0, ovf, empty, full, 8'b0, 8'(count)};
                    default: bus_rdata <= '0;
                endcase
            end
        end
    end

    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !irq); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && (bus_addr == A_IEN || bus_addr == A_IDIS))
        |=> $stable(mask)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_ovf_clr) |=> ovf); // R9
endmodule

// File: tb/txts_collector_tb.sv
module txts_collector_tb;
    localparam int NP = 4;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     port_valid = '0;
    logic [NP-1:0]     port_ready;
    logic [NP*28-1:0]  port_ts_rise = '0;
    logic [NP*4-1:0]   port_ts_fall = '0;
    logic [NP*16-1:0]  port_frame_id = '0;
    logic              adj_busy = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int total = 0;
    int fails = 0;
    int rr = 0;
    logic [31:0] qw0[$], qw1[$], qw2[$];
    logic [31:0] rd;

    always #5 clk = ~clk;

    txts_collector #(.N_PORTS(NP), .DEPTH_LOG2(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_valid(port_valid), .port_ready(port_ready),
        .port_ts_rise(port_ts_rise), .port_ts_fall(port_ts_fall),
        .port_frame_id(port_frame_id), .adj_busy(adj_busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    // offer entries on the ports in 'set'; round k selects data
    task automatic present(input logic [NP-1:0] set, input int k, input logic busy, input logic dup);
        logic [NP-1:0] pending;
        for (int p = 0; p < NP; p++) begin
            port_ts_rise[p*28 +: 28] = 28'(32'h0ABCDE0 + k*1000 + p*7);
            port_ts_fall[p*4 +: 4]   = 4'(k + p);
            port_frame_id[p*16 +: 16] = dup ? 16'(k) : 16'(k*16 + p);
        end
        adj_busy = busy;
        pending = set;
        while (pending != '0) begin
            int g;
            g = -1;
            @(negedge clk);
            port_valid = pending;
            #1;
            for (int i = 0; i < NP; i++)
                if (g < 0 && pending[(rr + i) % NP]) g = (rr + i) % NP;
            chk("R4 grant", 32'(port_ready), 32'(1 << g));
            if (qw0.size() < DEPTH) begin
                qw0.push_back({port_ts_fall[g*4 +: 4], port_ts_rise[g*28 +: 28]});
                qw1.push_back({port_frame_id[g*16 +: 16], 11'b0, 5'(g)});
                qw2.push_back({31'b0, busy});
            end
            rr = (g + 1) % NP;
            pending[g] = 1'b0;
        end
        @(negedge clk);
        port_valid = '0;
        adj_busy = 1'b0;
    endtask

    task automatic drain;
        while (qw0.size() > 0) begin
            bus_read(5'h10, rd); chk("R6 word0", rd, qw0.pop_front());
            bus_read(5'h14, rd); chk("R7 word1", rd, qw1[0]);
            bus_read(5'h18, rd); chk("R8 word2", rd, qw2.pop_front());
            bus_read(5'h14, rd); chk("R11 word1 no pop", rd, qw1.pop_front());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ready", 32'(port_ready), 0);
        bus_read(5'h1C, rd); chk("R1 csr", rd, 32'h0002_0000);
        bus_read(5'h08, rd); chk("R1 mask", rd, 0);

        bus_write(5'h04, 1); bus_read(5'h08, rd); chk("R2 enable", rd, 1);
        bus_write(5'h08, 0); bus_read(5'h08, rd); chk("R2 mask ro", rd, 1);
        bus_write(5'h00, 0); bus_read(5'h08, rd); chk("R2 dis zero", rd, 1);
        bus_write(5'h00, 1); bus_read(5'h08, rd); chk("R2 disable", rd, 0);
        bus_write(5'h04, 0); bus_read(5'h08, rd); chk("R2 en zero", rd, 0);

        present(4'b0100, 99, 1'b0, 1'b0);
        #1 chk("R3 irq masked", 32'(irq), 0);
        bus_read(5'h0C, rd); chk("R3 status masked", rd, 0);
        bus_write(5'h04, 1);
        #1 chk("R3 irq on", 32'(irq), 1);
        bus_read(5'h0C, rd); chk("R3 status on", rd, 1);
        drain();
        #1 chk("R3 irq off", 32'(irq), 0);

        for (int s = 1; s < 16; s++) begin
            present(4'(s), s, (s % 3) == 0, s[0]);
            bus_read(5'h1C, rd); chk("R5 count", rd, 32'($countones(s)));
            #1 chk("R3 irq pend", 32'(irq), 1);
            drain();
            bus_read(5'h1C, rd); chk("R5 empty", rd, 32'h0002_0000);
        end

        bus_read(5'h10, rd); chk("R10 w0 empty", rd, 0);
        bus_read(5'h14, rd); chk("R10 w1 none", rd, 0);
        bus_read(5'h18, rd); chk("R10 w2 none", rd, 0);

        present(4'b1111, 200, 1'b1, 1'b1);
        present(4'b1111, 201, 1'b0, 1'b0);
        bus_read(5'h1C, rd); chk("R5 full", rd, 32'h0001_0008);
        present(4'b0010, 202, 1'b0, 1'b0);
        bus_read(5'h1C, rd); chk("R9 drop ovf", rd, 32'h0005_0008);
        bus_write(5'h1C, 0);
        bus_read(5'h1C, rd); chk("R9 sticky", rd, 32'h0005_0008);
        bus_write(5'h1C, 32'h0004_0000);
        bus_read(5'h1C, rd); chk("R9 clear", rd, 32'h0001_0008);
        drain();
        bus_read(5'h1C, rd); chk("R11 end empty", rd, 32'h0002_0000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule